// File: doc/BRIEF.md
# CPU Debug Halt Control Unit

This block sits on the debug side of a small 16-bit processor and decides whether the CPU runs. It holds two registers behind a simple, already-synchronised register port: a control register and a memory data register. It also drives a halt request into the CPU core. The serial transport in front of the port is outside the block. Its only trace here is a synchronisation event, which the port must see before it will honour any access.

After a power-on reset the unit waits for the debug-enable input to pass through a two-flop synchroniser. It then decides whether to hold the CPU. The CPU is held only when debug is enabled at that moment and the reset-break parameter is set; in every other case the CPU runs. A host releases or halts the CPU by writing command bits into the control register.

Pulling debug-enable low clears the debug logic and leaves the CPU alone. The active-low system reset clears both the debug logic and the CPU.

Top module: `dbg_halt_unit`

## Requirements
- R1: After any reset of the debug logic, the control register (address 0) reads 16'h0030 when RST_BRK_EN=1 and 16'h0010 when RST_BRK_EN=0. Bit 5 holds the reset-break setting and bit 4 is set at reset.
- R2: After a system reset released with dbgEnable high and RST_BRK_EN=1, haltReq rises within 4 clocks and stays high. With RST_BRK_EN=0, haltReq stays low.
- R3: If dbgEnable is low while the system reset is released, haltReq stays low whatever RST_BRK_EN is.
- R4: Raising dbgEnable after the reset has finished never raises haltReq.
- R5: Writing the control register with bit 1 set (run) drops haltReq on the next clock. Bit 0 set (halt) raises haltReq, and halt wins when both bits are set. Bits 1 and 0 read back as 0. Only bits 5 and 4 are stored, so writing 16'h0000 reads back 16'h0000.
- R6: The memory data register (address 1) stores and returns any 16-bit value, and it resets to 16'h0000.
- R7: dbgEnable held low across at least one clock edge does three things. It returns both registers to their reset values, drops haltReq and forgets the synchronisation. cpuReset stays low throughout.
- R8: rstN low drives cpuReset high and clears the debug registers to their reset values.
- R9: After any reset of the debug logic, reads return 16'h0000 and writes are ignored until syncEvent has been seen.
- R10: Addresses other than 0 and 1 read as 16'h0000, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous system reset |
| dbgEnable | input | 1 | Asynchronous debug enable; when low, the debug logic is held in reset |
| syncEvent | input | 1 | One-clock pulse telling the port that the transport is synchronised |
| regSel | input | ADDR_W (3) | Register address |
| regWr | input | 1 | Write strobe for the addressed register |
| regWdata | input | DATA_W (16) | Write data |
| regRdata | output | DATA_W (16) | Read data of the addressed register (combinational) |
| haltReq | output | 1 | Halt request to the CPU |
| cpuReset | output | 1 | Active-high CPU reset, driven only by rstN |

## Verification
Two copies of the unit, one with reset-break on and one with it off, run side by side on the same stimulus. Every difference between their halt requests and control-register values can therefore be traced to the parameter alone.

The reset patterns are chosen to separate the effect of each reset source:
- a system reset with debug enabled
- a system reset with debug disabled and enabled later
- a one-clock drop of debug-enable

Register traffic is replayed before and after the synchronisation event, and on unmapped addresses. This shows whether accesses are honoured only when they should be.

Run and halt commands are written alone and together, which exposes the priority between them.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

  // Register addresses: the host software decodes these, so they are fixed.
  localparam int ADDR_CTL = 0;
  localparam int ADDR_MEM = 1;

  // Control register bit positions
  localparam int CTL_BRK_BIT  = 5;
  localparam int CTL_FIX_BIT  = 4;
  localparam int CTL_RUN_BIT  = 1;
  localparam int CTL_HALT_BIT = 0;

  // Strobes from control to datapath
  typedef struct packed {
    logic clr;    // debug logic in reset
    logic ctlWr;  // accepted write to control register
    logic memWr;  // accepted write to memory data register
    logic rdEn;   // reads are honoured
  } dpStrobe_t;

endpackage

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter bit RST_BRK_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dbgEnable,
  input  logic              syncEvent,
  input  logic [ADDR_W-1:0] regSel,
  input  logic              regWr,
  input  logic              runBit,
  input  logic              haltBit,
  output dpStrobe_t         strb,
  output logic              haltReq
);

  localparam int CNT_MAX = SYNC_STAGES + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [SYNC_STAGES-1:0] enPipe;
  logic                   dbgEnSync;
  logic [CNT_W-1:0]       porCnt;
  logic                   porCheck;
  logic                   synced;
  logic                   accept;
  logic                   selCtl;
  logic                   selMem;
  logic                   runCmd;
  logic                   haltCmd;

  // Debug-enable synchroniser, one flop per stage
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)  enPipe[i] <= 1'b0;
      else if (i == 0) enPipe[i] <= dbgEnable;
      else        enPipe[i] <= enPipe[(i == 0) ? 0 : i-1];
    end
  end
  assign dbgEnSync = enPipe[SYNC_STAGES-1];

  // Window after system reset: decision taken once the synchroniser has settled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          porCnt <= '0;
    else if (porCnt != CNT_MAX[CNT_W-1:0]) porCnt <= porCnt + 1'b1;
  end
  assign porCheck = (porCnt == SYNC_STAGES[CNT_W-1:0]);

  // Transport synchronisation state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           synced <= 1'b0;
    else if (!dbgEnSync) synced <= 1'b0;
    else if (syncEvent)  synced <= 1'b1;
  end

  assign accept  = synced && dbgEnSync && regWr;
  assign selCtl  = (regSel == ADDR_CTL[ADDR_W-1:0]);
  assign selMem  = (regSel == ADDR_MEM[ADDR_W-1:0]);
  assign runCmd  = accept && selCtl && runBit;
  assign haltCmd = accept && selCtl && haltBit;

  assign strb.clr   = !dbgEnSync;
  assign strb.ctlWr = accept && selCtl;
  assign strb.memWr = accept && selMem;
  assign strb.rdEn  = synced && dbgEnSync;

  // Halt request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      haltReq <= 1'b0;
    else if (!dbgEnSync)            haltReq <= 1'b0;
    else if (porCheck && RST_BRK_EN) haltReq <= 1'b1;
    else if (haltCmd)               haltReq <= 1'b1;
    else if (runCmd)                haltReq <= 1'b0;
  end

  AST_HALT_NEEDS_DBG: assert property (@(posedge clk) disable iff (!rstN)
    !dbgEnSync |=> !haltReq);                                   // R7
  AST_RUN_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (runCmd && !haltCmd && !porCheck) |=> !haltReq);            // R5
  AST_HALT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltReq) |-> ($past(haltCmd) || $past(porCheck)));    // R4
  AST_SYNC_LOST: assert property (@(posedge clk) disable iff (!rstN)
    !dbgEnSync |=> !synced);                                    // R9

endmodule

// File: rtl/dbg_halt_dpath.sv
module dbg_halt_dpath
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 16,
  parameter bit RST_BRK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] regSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata
);

  localparam logic [1:0] CTL_RST = {RST_BRK_EN, 1'b1};

  logic [1:0]        ctlKeep;   // {break setting, fixed flag}
  logic [DATA_W-1:0] memData;
  logic [DATA_W-1:0] ctlView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ctlKeep <= CTL_RST;
    else if (strb.clr)   ctlKeep <= CTL_RST;
    else if (strb.ctlWr) ctlKeep <= {regWdata[CTL_BRK_BIT], regWdata[CTL_FIX_BIT]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           memData <= '0;
    else if (strb.clr)   memData <= '0;
    else if (strb.memWr) memData <= regWdata;
  end

  always_comb begin
    ctlView = '0;
    ctlView[CTL_BRK_BIT] = ctlKeep[1];
    ctlView[CTL_FIX_BIT] = ctlKeep[0];
  end

  always_comb begin
    regRdata = '0;
    if (strb.rdEn) begin
      if (regSel == ADDR_CTL[ADDR_W-1:0])      regRdata = ctlView;
      else if (regSel == ADDR_MEM[ADDR_W-1:0]) regRdata = memData;
    end
  end

  AST_CLEAR_MEM: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (memData == '0));                              // R7
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.memWr && !strb.clr) |=> $stable(memData));           // R10
  AST_CTL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (ctlKeep == CTL_RST));                         // R1

endmodule

// File: rtl/dbg_halt_unit.sv
module dbg_halt_unit
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit RST_BRK_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dbgEnable,
  input  logic              syncEvent,
  input  logic [ADDR_W-1:0] regSel,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              haltReq,
  output logic              cpuReset
);

  dpStrobe_t strb;

  dbg_halt_ctrl #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .RST_BRK_EN(RST_BRK_EN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .dbgEnable(dbgEnable), .syncEvent(syncEvent),
    .regSel(regSel), .regWr(regWr),
    .runBit(regWdata[CTL_RUN_BIT]), .haltBit(regWdata[CTL_HALT_BIT]),
    .strb(strb), .haltReq(haltReq)
  );

  dbg_halt_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_BRK_EN(RST_BRK_EN)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  // The CPU is reset only by the system reset, never by debug-enable
  assign cpuReset = !rstN;

  AST_CPU_RST_FOLLOWS: assert property (@(posedge clk)
    rstN |-> !cpuReset);                                        // R8

endmodule

// File: tb/dbg_halt_unit_test.sv
`timescale 1ns/1ps
module dbg_halt_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dbgEnable = 1'b1;
  logic        syncEvent = 1'b0;
  logic [2:0]  regSel = '0;
  logic        regWr = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] rdA, rdB;
  logic        haltA, haltB, cpuRstA, cpuRstB;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dbg_halt_unit #(.RST_BRK_EN(1'b1)) uut (
    .clk(clk), .rstN(rstN), .dbgEnable(dbgEnable), .syncEvent(syncEvent),
    .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
    .regRdata(rdA), .haltReq(haltA), .cpuReset(cpuRstA));

  dbg_halt_unit #(.RST_BRK_EN(1'b0)) uutNb (
    .clk(clk), .rstN(rstN), .dbgEnable(dbgEnable), .syncEvent(syncEvent),
    .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
    .regRdata(rdB), .haltReq(haltB), .cpuReset(cpuRstB));

  // {wr, sel[2:0], wdata[15:0], expected read[15:0]}
  localparam int NVEC = 13;
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b1, 3'd1, 16'haa55, 16'h0000},
    {1'b0, 3'd1, 16'h0000, 16'haa55},
    {1'b1, 3'd0, 16'h0000, 16'h0000},
    {1'b0, 3'd0, 16'h0000, 16'h0000},
    {1'b1, 3'd0, 16'hfffc, 16'h0000},
    {1'b0, 3'd0, 16'h0000, 16'h0030},
    {1'b1, 3'd5, 16'h1234, 16'h0000},
    {1'b0, 3'd5, 16'h0000, 16'h0000},
    {1'b0, 3'd1, 16'h0000, 16'haa55},
    {1'b1, 3'd1, 16'hffff, 16'h0000},
    {1'b0, 3'd1, 16'h0000, 16'hffff},
    {1'b1, 3'd7, 16'h0000, 16'h0000},
    {1'b0, 3'd1, 16'h0000, 16'hffff}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] sel, input logic [15:0] data);
    @(negedge clk);
    regSel = sel; regWr = 1'b1; regWdata = data;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  // Sets the address at a falling edge and samples the combinational read 2 ns later
  task automatic rdReg(input logic [2:0] sel);
    @(negedge clk);
    regSel = sel; regWr = 1'b0;
    #2;
  endtask

  task automatic sendSync;
    @(negedge clk); syncEvent = 1'b1;
    @(negedge clk); syncEvent = 1'b0;
  endtask

  task automatic sysReset(input logic en);
    @(negedge clk);
    dbgEnable = en; rstN = 1'b0;
    #2;
    chk("R8 cpuReset high", {15'd0, cpuRstA}, 16'd1);
    @(negedge clk); rstN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Power-on reset with debug enabled
    sysReset(1'b1);
    #1;
    chk("R2 halt with break on", {15'd0, haltA}, 16'd1);
    chk("R2 no halt with break off", {15'd0, haltB}, 16'd0);
    chk("R8 cpuReset low after reset", {15'd0, cpuRstA}, 16'd0);

    // R9: nothing before sync
    rdReg(3'd0);
    chk("R9 read before sync", rdA, 16'h0000);
    wrReg(3'd1, 16'h1111);
    sendSync;
    rdReg(3'd0);
    chk("R1 ctl reset break on", rdA, 16'h0030);
    chk("R1 ctl reset break off", rdB, 16'h0010);
    rdReg(3'd1);
    chk("R9 write before sync ignored / R6 reset", rdA, 16'h0000);

    // R5 run / halt commands
    wrReg(3'd0, 16'h0002);
    chk("R5 run clears halt", {15'd0, haltA}, 16'd0);
    wrReg(3'd0, 16'h0001);
    chk("R5 halt sets halt", {15'd0, haltA}, 16'd1);
    wrReg(3'd0, 16'h0002);
    chk("R5 run again", {15'd0, haltA}, 16'd0);
    wrReg(3'd0, 16'h0003);
    chk("R5 halt wins", {15'd0, haltA}, 16'd1);
    chk("R5 halt wins break off", {15'd0, haltB}, 16'd1);

    // Vector walk: R6 storage, R5 ctl bits, R10 unmapped addresses
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][35]) wrReg(VEC[i][34:32], VEC[i][31:16]);
      else begin
        rdReg(VEC[i][34:32]);
        chk("R6/R5/R10 vector read", rdA, VEC[i][15:0]);
        chk("R6/R5/R10 vector read nb", rdB, VEC[i][15:0]);
      end
    end

    // R7: one-clock drop of debug-enable while halted
    wrReg(3'd0, 16'h0001);
    wrReg(3'd1, 16'haa55);
    @(negedge clk); dbgEnable = 1'b0;
    @(negedge clk); dbgEnable = 1'b1;
    chk("R7 cpuReset stays low", {15'd0, cpuRstA}, 16'd0);
    repeat (6) @(negedge clk);
    chk("R7 halt dropped / R4 not re-raised", {15'd0, haltA}, 16'd0);
    chk("R7 cpuReset still low", {15'd0, cpuRstA}, 16'd0);
    rdReg(3'd1);
    chk("R9 unsynced after debug reset", rdA, 16'h0000);
    sendSync;
    rdReg(3'd0);
    chk("R7 ctl back to reset", rdA, 16'h0030);
    chk("R7 ctl back to reset nb", rdB, 16'h0010);
    rdReg(3'd1);
    chk("R7 mem cleared", rdA, 16'h0000);

    // R3 / R4: reset with debug disabled, then enable
    sysReset(1'b0);
    #1;
    chk("R3 no halt, break on", {15'd0, haltA}, 16'd0);
    chk("R3 no halt, break off", {15'd0, haltB}, 16'd0);
    @(negedge clk); dbgEnable = 1'b1;
    repeat (10) @(negedge clk);
    chk("R4 enable later no halt", {15'd0, haltA}, 16'd0);
    sendSync;
    wrReg(3'd1, 16'haa55);
    rdReg(3'd1);
    chk("R6 mem write after late enable", rdA, 16'haa55);

    // R8: system reset clears registers
    sysReset(1'b1);
    sendSync;
    rdReg(3'd1);
    chk("R8 mem cleared by system reset", rdA, 16'h0000);
    rdReg(3'd0);
    chk("R8 ctl reset value", rdA, 16'h0030);
    chk("R2 halt again after reset", {15'd0, haltA}, 16'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule